// File: doc/BRIEF.md
# Per-Channel Offset and Gain Calibration Datapath

This block corrects signed conversion samples with a calibration pair that is held for each input channel. For every accepted sample it first removes a 24-bit two's-complement offset and then scales the difference by a 24-bit unsigned gain word. In the gain word the value 400000h means a factor of exactly one. The result clamps to the 24-bit signed range. It leaves the block two clock cycles after the sample, together with the sample's channel tag.

Calibration words are loaded one byte at a time through a write-only port. The addresses are fixed. Channel n keeps its offset in three consecutive bytes starting at 13h + 8n, most significant byte first. It keeps its gain in three bytes starting at 16h + 8n, in the same order. A reduced-resolution mode carries 16-bit samples. Each such sample is aligned to the top of the 24-bit path, and the 16 most significant bits of the corrected value are returned.

Top module: `cal_datapath`

## Requirements
- R1: While reset is asserted, `res_valid_o` is 0 and `res_data_o` is 0. After reset every offset is 000000h and every gain is 400000h, so in 24-bit mode each sample comes out unchanged.
- R2: A write with `cfg_we_i`=1 stores `cfg_wdata_i` into one byte. For channel n, offset bits [23:16], [15:8] and [7:0] are at addresses 13h+8n, 14h+8n and 15h+8n. Gain bits [23:16], [15:8] and [7:0] are at 16h+8n, 17h+8n and 18h+8n. A write to any other address changes no stored word.
- R3: In 24-bit mode the output is floor((x − offset) × gain / 2^22). Here x is `smp_data_i` read as signed, and offset and gain are the words of channel `smp_ch_i`. The computation keeps full precision, with no wrap in any intermediate value.
- R4: A result above 7FFFFFh is output as 7FFFFFh, and a result below −800000h is output as 800000h. A strictly positive difference never gives a negative output.
- R5: A sample accepted on a clock edge, with `smp_valid_i`=1, produces `res_valid_o`=1 after the second following edge, carrying its `smp_ch_i` on `res_ch_o`. A cycle with `smp_valid_i`=0 produces `res_valid_o`=0 two edges later.
- R6: With `half_res_i`=1 at acceptance, the sample is `smp_data_i[15:0]` (signed) shifted left by 8 bits. The output is bits [23:8] of the clamped R3/R4 result on `res_data_o[15:0]`, with `res_data_o[23:16]` copying bit 15.
- R7: A sample uses only the calibration words of its own channel. Words of other channels have no effect on it.
- R8: A byte written on the same edge that accepts a sample is not seen by that sample. It applies to samples accepted on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Calibration byte write strobe |
| cfg_addr_i | input | 8 | Calibration byte address |
| cfg_wdata_i | input | 8 | Calibration byte value |
| half_res_i | input | 1 | 16-bit reduced-resolution mode |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_ch_i | input | 3 | Channel tag of the sample |
| smp_data_i | input | 24 | Signed sample (low 16 bits in 16-bit mode) |
| res_valid_o | output | 1 | Corrected result present |
| res_ch_o | output | 3 | Channel tag of the result |
| res_data_o | output | 24 | Corrected, clamped result |

## Verification
The bench first uses reset defaults, where the output must equal the input; this exposes errors in the reset values and the alignment. Random offsets, gains and samples in both modes then separate truncation toward minus infinity from rounding toward zero, and show whether the 16-bit path is aligned correctly. Extreme values drive both saturation limits. They also catch a product or difference that wraps instead of clamping. Interleaved channels with distinct words, writes to unmapped addresses, and writes on the same edge as a sample catch wrong address decoding, channels that interfere with each other, and a write that reaches a sample too early.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned CAL_CH_N   = 8;
  localparam int unsigned CAL_DW     = 24;
  localparam int unsigned CAL_FRAC   = 22;
  localparam int unsigned CAL_HALF_W = 16;
  localparam int unsigned CAL_ADDR_W = 8;
  localparam int unsigned CAL_BASE   = 'h13;
  localparam int unsigned CAL_STRIDE = 8;
  localparam int unsigned CAL_GAP    = 3;
endpackage

// File: rtl/cal_regfile.sv
module cal_regfile #(
  parameter int unsigned CH_N   = cal_pkg::CAL_CH_N,
  parameter int unsigned DW     = cal_pkg::CAL_DW,
  parameter int unsigned ADDR_W = cal_pkg::CAL_ADDR_W,
  parameter int unsigned BASE   = cal_pkg::CAL_BASE,
  parameter int unsigned STRIDE = cal_pkg::CAL_STRIDE,
  parameter int unsigned GAP    = cal_pkg::CAL_GAP,
  parameter logic [DW-1:0] UNITY = '0,
  localparam int unsigned CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DW-1:0]     off_o,
  output logic [DW-1:0]     gain_o
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] off_q  [CH_N];
  logic [DW-1:0] gain_q [CH_N];
  logic [CH_N-1:0][NB-1:0] hit_off, hit_gain;

  // byte b of a word sits at word base + b, most significant first
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(BASE + STRIDE*c + b);
      localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(BASE + STRIDE*c + GAP + b);
      assign hit_off[c][b]  = we_i && (addr_i == A_OFF);
      assign hit_gain[c][b] = we_i && (addr_i == A_GAIN);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < CH_N; c++) begin
        off_q[c]  <= '0;
        gain_q[c] <= UNITY;
      end
    end else begin
      for (int c = 0; c < CH_N; c++) begin
        for (int b = 0; b < NB; b++) begin
          if (hit_off[c][b])  off_q[c][8*(NB-1-b) +: 8]  <= wdata_i;
          if (hit_gain[c][b]) gain_q[c][8*(NB-1-b) +: 8] <= wdata_i;
        end
      end
    end
  end

  assign off_o  = off_q[rd_ch_i];
  assign gain_o = gain_q[rd_ch_i];
endmodule

// File: rtl/cal_sub_stage.sv
module cal_sub_stage #(
  parameter int unsigned DW     = cal_pkg::CAL_DW,
  parameter int unsigned HALF_W = cal_pkg::CAL_HALF_W,
  parameter int unsigned CH_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic                half_i,
  input  logic [DW-1:0]       data_i,
  input  logic [DW-1:0]       off_i,
  input  logic [DW-1:0]       gain_i,
  output logic                valid_o,
  output logic [CH_W-1:0]     ch_o,
  output logic                half_o,
  output logic signed [DW:0]  diff_o,
  output logic [DW-1:0]       gain_o
);
  logic [DW-1:0]      aligned;
  logic signed [DW:0] diff_d;

  // 16-bit samples are left-justified into the full-width path
  assign aligned = half_i ? {data_i[HALF_W-1:0], {(DW-HALF_W){1'b0}}} : data_i;
  assign diff_d  = $signed({aligned[DW-1], aligned}) - $signed({off_i[DW-1], off_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      half_o  <= 1'b0;
      diff_o  <= '0;
      gain_o  <= '0;
    end else begin
      valid_o <= valid_i;
      ch_o    <= ch_i;
      half_o  <= half_i;
      diff_o  <= diff_d;
      gain_o  <= gain_i;
    end
  end
endmodule

// File: rtl/cal_mul_stage.sv
module cal_mul_stage #(
  parameter int unsigned DW     = cal_pkg::CAL_DW,
  parameter int unsigned FRAC   = cal_pkg::CAL_FRAC,
  parameter int unsigned HALF_W = cal_pkg::CAL_HALF_W,
  parameter int unsigned CH_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic                half_i,
  input  logic signed [DW:0]  diff_i,
  input  logic [DW-1:0]       gain_i,
  output logic                valid_o,
  output logic [CH_W-1:0]     ch_o,
  output logic [DW-1:0]       data_o
);
  localparam int unsigned PW = 2*DW + 2;

  logic signed [PW-1:0] prod, shifted;
  logic                 ovf;
  logic [DW-1:0]        sat, packed_res;

  assign prod    = PW'(diff_i) * PW'($signed({1'b0, gain_i}));
  assign shifted = prod >>> FRAC;  // floor toward minus infinity
  // overflow when the bits above the result sign disagree with it
  assign ovf     = !((&shifted[PW-1:DW-1]) || !(|shifted[PW-1:DW-1]));
  assign sat     = ovf ? {shifted[PW-1], {(DW-1){~shifted[PW-1]}}} : shifted[DW-1:0];
  assign packed_res = half_i ? {{(DW-HALF_W){sat[DW-1]}}, sat[DW-1 -: HALF_W]} : sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      ch_o    <= ch_i;
      data_o  <= packed_res;
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath #(
  parameter int unsigned CH_N   = cal_pkg::CAL_CH_N,
  parameter int unsigned DW     = cal_pkg::CAL_DW,
  parameter int unsigned FRAC   = cal_pkg::CAL_FRAC,
  parameter int unsigned HALF_W = cal_pkg::CAL_HALF_W,
  parameter int unsigned ADDR_W = cal_pkg::CAL_ADDR_W,
  parameter int unsigned BASE   = cal_pkg::CAL_BASE,
  parameter int unsigned STRIDE = cal_pkg::CAL_STRIDE,
  parameter int unsigned GAP    = cal_pkg::CAL_GAP,
  localparam int unsigned CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              half_res_i,
  input  logic              smp_valid_i,
  input  logic [CH_W-1:0]   smp_ch_i,
  input  logic [DW-1:0]     smp_data_i,
  output logic              res_valid_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic [DW-1:0]     res_data_o
);
  localparam logic [DW-1:0] UNITY = DW'(1) << FRAC;

  logic [DW-1:0]      cur_off, cur_gain;
  logic               s1_valid, s1_half;
  logic [CH_W-1:0]    s1_ch;
  logic signed [DW:0] s1_diff;
  logic [DW-1:0]      s1_gain;

  cal_regfile #(
    .CH_N(CH_N), .DW(DW), .ADDR_W(ADDR_W), .BASE(BASE),
    .STRIDE(STRIDE), .GAP(GAP), .UNITY(UNITY)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .rd_ch_i(smp_ch_i), .off_o(cur_off), .gain_o(cur_gain)
  );

  cal_sub_stage #(.DW(DW), .HALF_W(HALF_W), .CH_W(CH_W)) u_sub (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(smp_valid_i), .ch_i(smp_ch_i),
    .half_i(half_res_i), .data_i(smp_data_i), .off_i(cur_off), .gain_i(cur_gain),
    .valid_o(s1_valid), .ch_o(s1_ch), .half_o(s1_half), .diff_o(s1_diff), .gain_o(s1_gain)
  );

  cal_mul_stage #(.DW(DW), .FRAC(FRAC), .HALF_W(HALF_W), .CH_W(CH_W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(s1_valid), .ch_i(s1_ch),
    .half_i(s1_half), .diff_i(s1_diff), .gain_i(s1_gain),
    .valid_o(res_valid_o), .ch_o(res_ch_o), .data_o(res_data_o)
  );
endmodule

// File: rtl/cal_datapath_chk.sv
module cal_datapath_chk #(
  parameter int unsigned DW     = 24,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic [CH_W-1:0]   smp_ch_i,
  input logic              half_res_i,
  input logic              res_valid_o,
  input logic [CH_W-1:0]   res_ch_o,
  input logic [DW-1:0]     res_data_o,
  input logic              s1_valid,
  input logic signed [DW:0] s1_diff
);
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_valid_o && res_data_o == '0)); // R1
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc[1] |-> (res_valid_o == $past(smp_valid_i, 2))); // R5
  AST_CH_TRAVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc[1] && res_valid_o) |-> (res_ch_o == $past(smp_ch_i, 2))); // R5
  AST_ZERO_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_diff == '0) |=> (res_valid_o && res_data_o == '0)); // R3
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && !s1_diff[DW] && s1_diff != '0) |=> !res_data_o[DW-1]); // R4
  AST_HALF_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc[1] && res_valid_o && $past(half_res_i, 2)) |->
      (res_data_o[DW-1:HALF_W] == {(DW-HALF_W){res_data_o[HALF_W-1]}})); // R6
endmodule

bind cal_datapath cal_datapath_chk #(.DW(DW), .HALF_W(HALF_W), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_ch_i(smp_ch_i),
  .half_res_i(half_res_i), .res_valid_o(res_valid_o), .res_ch_o(res_ch_o),
  .res_data_o(res_data_o), .s1_valid(s1_valid), .s1_diff(s1_diff)
);

// File: tb/tb_cal_datapath.sv
`timescale 1ns/1ps
module tb_cal_datapath;
  logic clk = 1'b0;
  logic rst_n;
  logic we, half, vld;
  logic [7:0] addr, wdat;
  logic [2:0] ch;
  logic [23:0] smp;
  logic res_v;
  logic [2:0] res_ch;
  logic [23:0] res_d;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  cal_datapath dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdat), .half_res_i(half), .smp_valid_i(vld), .smp_ch_i(ch),
    .smp_data_i(smp), .res_valid_o(res_v), .res_ch_o(res_ch), .res_data_o(res_d)
  );

  // reference model
  logic [23:0] m_off [8];
  logic [23:0] m_gain [8];
  logic        e1_v, e2_v;
  logic [2:0]  e1_ch, e2_ch;
  logic [23:0] e1_d, e2_d;

  function automatic logic [23:0] ref_cal(logic [23:0] d, bit h, logic [23:0] o, logic [23:0] g);
    longint x, q;
    logic [23:0] r;
    x = h ? longint'($signed(d[15:0])) * 256 : longint'($signed(d));
    q = ((x - longint'($signed(o))) * longint'(g)) >>> 22;
    if (q > 64'sd8388607) q = 64'sd8388607;
    if (q < -64'sd8388608) q = -64'sd8388608;
    r = q[23:0];
    if (h) r = {{8{r[23]}}, r[23:8]};
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin m_off[n] = '0; m_gain[n] = 24'h400000; end
      e1_v = 0; e2_v = 0; e1_ch = 0; e2_ch = 0; e1_d = 0; e2_d = 0;
    end else begin
      e2_v = e1_v; e2_ch = e1_ch; e2_d = e1_d;
      e1_v = vld; e1_ch = ch;
      e1_d = ref_cal(smp, half, m_off[ch], m_gain[ch]);
      if (we) begin
        for (int n = 0; n < 8; n++) begin
          for (int k = 0; k < 3; k++) begin
            if (addr == 8'(8'h13 + 8*n + k)) m_off[n][8*(2-k) +: 8] = wdat;
            if (addr == 8'(8'h16 + 8*n + k)) m_gain[n][8*(2-k) +: 8] = wdat;
          end
        end
      end
    end
  end

  task automatic chk(string t, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(tag, res_v, e2_v);
      if (e2_v) begin
        chk(tag, res_ch, e2_ch);
        chk(tag, res_d, e2_d);
      end
    end
  end

  task automatic drive(bit w, logic [7:0] a, logic [7:0] d, bit v, logic [2:0] c,
                       logic [23:0] s, bit h);
    @(negedge clk);
    we = w; addr = a; wdat = d; vld = v; ch = c; smp = s; half = h;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 8'h00, 0, 3'd0, 24'h0, 0);
  endtask

  task automatic put_word(bit is_gain, int c, logic [23:0] val);
    for (int k = 0; k < 3; k++)
      drive(1, 8'(8'h13 + 8*c + (is_gain ? 3 : 0) + k), val[8*(2-k) +: 8], 0, 3'd0, 24'h0, 0);
  endtask

  task automatic burst(int n, bit h, bit sparse);
    for (int i = 0; i < n; i++)
      drive(0, 8'h00, 8'h00, sparse ? 1'($urandom_range(0, 1)) : 1'b1,
            3'($urandom_range(0, 7)), 24'($urandom), h);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    we = 0; addr = 0; wdat = 0; vld = 1; ch = 0; smp = 24'h123456; half = 0;
    repeat (3) @(negedge clk);
    chk("R1", res_v, 0);  // valid held low under reset despite valid input
    chk("R1", res_d, 0);
    @(negedge clk);
    chk("R1", res_v, 0);
    vld = 0;
    rst_n = 1'b1;

    // R1: defaults pass samples through, including extremes
    tag = "R1";
    drive(0, 0, 0, 1, 3'd0, 24'h7FFFFF, 0);
    drive(0, 0, 0, 1, 3'd5, 24'h800000, 0);
    drive(0, 0, 0, 1, 3'd7, 24'hFFFFFF, 0);
    burst(16, 0, 0);
    idle(3);

    // R2: byte map, and unmapped addresses ignored
    tag = "R2";
    put_word(0, 3, 24'h00F00D);
    put_word(1, 3, 24'h2AB123);
    put_word(1, 7, 24'h512345);  // last mapped byte at 50h
    drive(1, 8'h12, 8'hFF, 0, 0, 0, 0);
    drive(1, 8'h19, 8'hFF, 0, 0, 0, 0);
    drive(1, 8'h51, 8'hFF, 0, 0, 0, 0);
    drive(1, 8'h00, 8'hFF, 0, 0, 0, 0);
    drive(1, 8'hFF, 8'hFF, 0, 0, 0, 0);
    for (int c = 0; c < 8; c++) drive(0, 0, 0, 1, 3'(c), 24'h1F0000, 0);
    idle(3);

    // R3: random words and samples, 24-bit
    tag = "R3";
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 8; c++) begin
        put_word(0, c, 24'($urandom));
        put_word(1, c, 24'($urandom_range(0, 24'h7FFFFF)));
      end
      burst(40, 0, 0);
    end
    idle(3);

    // R4: saturation both ways
    tag = "R4";
    put_word(0, 1, 24'h800000); put_word(1, 1, 24'hFFFFFF);
    put_word(0, 2, 24'h7FFFFF); put_word(1, 2, 24'hFFFFFF);
    drive(0, 0, 0, 1, 3'd1, 24'h7FFFFF, 0);
    drive(0, 0, 0, 1, 3'd2, 24'h800000, 0);
    drive(0, 0, 0, 1, 3'd1, 24'h000001, 0);
    drive(0, 0, 0, 1, 3'd2, 24'h7FFFFE, 0);
    drive(0, 0, 0, 1, 3'd1, 24'h800000, 1);
    drive(0, 0, 0, 1, 3'd2, 24'h000000, 1);
    idle(3);

    // R5: sparse valid, random channel tags
    tag = "R5";
    burst(200, 0, 1);
    idle(3);

    // R6: 16-bit mode, also mixed with 24-bit
    tag = "R6";
    burst(120, 1, 0);
    for (int i = 0; i < 60; i++)
      drive(0, 0, 0, 1, 3'($urandom_range(0, 7)), 24'($urandom), 1'($urandom_range(0, 1)));
    idle(3);

    // R7: distinct words per channel, interleaved channels
    tag = "R7";
    for (int c = 0; c < 8; c++) begin
      put_word(0, c, 24'(c * 24'h010101));
      put_word(1, c, 24'(24'h100000 * (c + 1)));
    end
    for (int i = 0; i < 64; i++) drive(0, 0, 0, 1, 3'(i % 8), 24'h300000, 0);
    idle(3);

    // R8: write on the same edge as a sample of that channel
    tag = "R8";
    drive(1, 8'h26, 8'h7F, 1, 3'd2, 24'h200000, 0);
    drive(1, 8'h23, 8'h40, 1, 3'd2, 24'h200000, 0);
    drive(0, 0, 0, 1, 3'd2, 24'h200000, 0);
    drive(1, 8'h1E, 8'h00, 1, 3'd1, 24'h600000, 0);
    drive(0, 0, 0, 1, 3'd1, 24'h600000, 0);
    idle(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule